// File: doc/BRIEF.md
# Debug Register File with Privilege and Access Trapping

This block is the architectural debug register file of a processor core. It has eight slots behind a single register-move port. Slots 0 to 3 hold breakpoint addresses. Slot 6 is the debug status word and slot 7 is the debug control word. Slots 4 and 5 are legacy aliases that reach the status and control words. Every access carries the current privilege level. In the same cycle as the request, the port answers with read data and a fault code.

Access control works in two layers. An access from any privilege level other than zero is refused with a general-protection code. When the general-detect enable in the control word is set, a privileged access is refused with a debug-exception code instead. That refusal records the access-detected flag in the status word and drops the general-detect enable, so that the handler which follows can reach the registers.

Neighbouring logic drives strobes into the block: a breakpoint matcher, single-step logic, task-switch logic and a bus-lock detector. These strobes update the status word and clear the local breakpoint enables in the control word.

Top module: `dbgreg_bank`

## Requirements
- R1: After reset, slots 0 to 3 read 0, the status word reads 32'hFFFF0FF0 and the control word reads 32'h00000400.
- R2: With no fault, a write to slot 0, 1, 2 or 3 stores all 32 bits, and a later read of that slot returns them.
- R3: Index 4 reads and writes the status word exactly as index 6 does, and index 5 reads and writes the control word exactly as index 7 does.
- R4: An access with privilege level not zero returns fault code 2'b01 (general protection) and read data 0, and it changes no register.
- R5: An access at privilege level zero while control bit 13 is set returns fault code 2'b10 (debug exception) and read data 0. It stores nothing. It sets status bit 13 and clears control bit 13.
- R6: The privilege check takes precedence over general detect: an unprivileged access while control bit 13 is set returns 2'b01 and leaves status bit 13 and control bit 13 unchanged.
- R7: A task-switch strobe clears control bits 0, 2, 4 and 6 and leaves every other control bit unchanged.
- R8: Control bit 10 always reads 1. Control bits 15:14, 12 and 11 always read 0. All other control bits are writable.
- R9: Status bits 31:16 and 10:4 always read 1, and status bit 12 always reads 0.
- R10: Status bits 3:0 are set by the matching bit of the breakpoint-hit strobe. They stay set until software writes the status word.
- R11: A single-step strobe sets status bit 14, and a task-trap strobe sets status bit 15.
- R12: A bus-lock strobe clears status bit 11. Only a software write to the status word sets it again.
- R13: Strobes that arrive in the same cycle all take effect together. A same-cycle software write to the status or control word overrides the hardware update of that word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_valid | input | 1 | Register-move request |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_idx | input | 3 | Slot index 0 to 7 |
| acc_cpl | input | 2 | Privilege level of the access |
| acc_wdata | input | 32 | Write data |
| acc_rdata | output | 32 | Read data, 0 on a fault or with no request |
| acc_fault | output | 2 | 00 none, 01 general protection, 10 debug exception |
| bp_hit | input | 4 | Breakpoint hit strobes, one per address slot |
| step_trap | input | 1 | Single-step trap strobe |
| task_trap | input | 1 | Switch into a trap-flagged task |
| task_sw | input | 1 | Task-switch strobe |
| buslock_trap | input | 1 | Bus-lock trap strobe |

## Verification
On every cycle, the assertions check the following. Unprivileged refusals leave the control and address state alone. A refused access returns zero data. The access-detected flag rises only through a debug-exception refusal or a software write. Breakpoint flags never fall without a status write. The bus-lock flag never rises through hardware. A task switch leaves the local enables at zero and the other control bits as they were. The readable encodings cannot be shown by those properties: the fixed-one and fixed-zero fields, the alias mapping, the precedence of the privilege check over general detect, and the result of same-cycle collisions. The directed scenarios in the bench show them by reading values back through the port.

// File: rtl/dbgreg_pkg.sv
package dbgreg_pkg;

  localparam int unsigned DW = 32;

  typedef enum logic [1:0] {
    FLT_NONE = 2'b00,
    FLT_GP   = 2'b01,
    FLT_DB   = 2'b10
  } fault_e;

  localparam logic [2:0] SLOT_STAT = 3'd6;
  localparam logic [2:0] SLOT_CTRL = 3'd7;

  // status word layout
  localparam int unsigned ST_BLD = 11;
  localparam int unsigned ST_BD  = 13;
  localparam int unsigned ST_BS  = 14;
  localparam int unsigned ST_BT  = 15;
  localparam logic [DW-1:0] ST_KEEP = 32'h0000_E80F;
  localparam logic [DW-1:0] ST_ONES = 32'hFFFF_07F0;
  localparam logic [DW-1:0] ST_RST  = 32'h0000_0800;

  // control word layout
  localparam int unsigned CT_GD = 13;
  localparam logic [DW-1:0] CT_KEEP = 32'hFFFF_23FF;
  localparam logic [DW-1:0] CT_ONES = 32'h0000_0400;
  localparam logic [DW-1:0] CT_RST  = 32'h0000_0000;

  // legacy slots fold onto status and control
  function automatic logic [2:0] canon_slot(input logic [2:0] idx);
    logic [2:0] s;
    case (idx)
      3'd4:    s = SLOT_STAT;
      3'd5:    s = SLOT_CTRL;
      default: s = idx;
    endcase
    return s;
  endfunction

  function automatic logic [DW-1:0] stat_view(input logic [DW-1:0] q);
    return (q & ST_KEEP) | ST_ONES;
  endfunction

  function automatic logic [DW-1:0] ctrl_view(input logic [DW-1:0] q);
    return (q & CT_KEEP) | CT_ONES;
  endfunction

  // even bits below 2*nbp are the per-task enables
  function automatic logic [DW-1:0] local_mask(input int unsigned nbp);
    logic [DW-1:0] m;
    m = '0;
    for (int unsigned i = 0; i < nbp; i++) m[2*i] = 1'b1;
    return m;
  endfunction

  // privilege first, general detect second
  function automatic fault_e classify(input logic valid, input logic [1:0] cpl,
                                      input logic gd);
    fault_e f;
    if (!valid)            f = FLT_NONE;
    else if (cpl != 2'd0)  f = FLT_GP;
    else if (gd)           f = FLT_DB;
    else                   f = FLT_NONE;
    return f;
  endfunction

endpackage

// File: rtl/dbgreg_access_gate.sv
module dbgreg_access_gate
  import dbgreg_pkg::*;
#(
  parameter int unsigned NUM_BP = 4
) (
  input  logic              acc_valid,
  input  logic              acc_write,
  input  logic [2:0]        acc_idx,
  input  logic [1:0]        acc_cpl,
  input  logic              gd_en,
  output fault_e            fault,
  output logic [2:0]        slot,
  output logic              rd_ok,
  output logic [NUM_BP-1:0] addr_we,
  output logic              stat_we,
  output logic              ctrl_we,
  output logic              db_event
);

  logic wr_ok;

  always_comb begin
    fault    = classify(acc_valid, acc_cpl, gd_en);
    slot     = canon_slot(acc_idx);
    wr_ok    = acc_valid && acc_write && (fault == FLT_NONE);
    rd_ok    = acc_valid && !acc_write && (fault == FLT_NONE);
    db_event = (fault == FLT_DB);
    stat_we  = wr_ok && (slot == SLOT_STAT);
    ctrl_we  = wr_ok && (slot == SLOT_CTRL);
  end

  for (genvar i = 0; i < NUM_BP; i++) begin : g_we
    assign addr_we[i] = wr_ok && (slot == 3'(i));
  end

  // a refused access never produces a write enable
  always_comb begin
    if (fault != FLT_NONE)
      AST_NO_WE_ON_FAULT: assert (!stat_we && !ctrl_we && (addr_we == '0)); // R4
  end

endmodule

// File: rtl/dbgreg_addr_bank.sv
module dbgreg_addr_bank #(
  parameter int unsigned NUM_BP = 4,
  parameter int unsigned DW     = 32
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [NUM_BP-1:0]          we,
  input  logic [DW-1:0]              wdata,
  output logic [NUM_BP-1:0][DW-1:0]  q
);

  for (genvar i = 0; i < NUM_BP; i++) begin : g_slot
    always_ff @(posedge clk) begin
      if (!rst_n)     q[i] <= '0;
      else if (we[i]) q[i] <= wdata;
    end

    AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !we[i] |=> $stable(q[i])); // R4
  end

endmodule

// File: rtl/dbgreg_status.sv
module dbgreg_status
  import dbgreg_pkg::*;
#(
  parameter int unsigned NUM_BP = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [DW-1:0]     wdata,
  input  logic [NUM_BP-1:0] hit,
  input  logic              step_trap,
  input  logic              task_trap,
  input  logic              buslock_trap,
  input  logic              bd_set,
  output logic [DW-1:0]     q
);

  logic [DW-1:0] hw_next;
  logic [DW-1:0] d;

  always_comb begin
    hw_next             = q;
    hw_next[NUM_BP-1:0] = q[NUM_BP-1:0] | hit;
    if (step_trap)    hw_next[ST_BS]  = 1'b1;
    if (task_trap)    hw_next[ST_BT]  = 1'b1;
    if (bd_set)       hw_next[ST_BD]  = 1'b1;
    if (buslock_trap) hw_next[ST_BLD] = 1'b0;
    d = (we ? wdata : hw_next) & ST_KEEP;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) q <= ST_RST;
    else        q <= d;
  end

  AST_BLD_NO_HW_SET: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(q[ST_BLD]) |-> $past(we)); // R12

  AST_HIT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    !we |=> ((q[NUM_BP-1:0] & $past(q[NUM_BP-1:0])) == $past(q[NUM_BP-1:0]))); // R10

  AST_STEP_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    (step_trap && !we) |=> q[ST_BS]); // R11

  AST_TASKTRAP_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    (task_trap && !we) |=> q[ST_BT]); // R11

endmodule

// File: rtl/dbgreg_control.sv
module dbgreg_control
  import dbgreg_pkg::*;
#(
  parameter int unsigned NUM_BP = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [DW-1:0] wdata,
  input  logic          task_sw,
  input  logic          gd_clr,
  output logic [DW-1:0] q,
  output logic          gd_en
);

  localparam logic [DW-1:0] LOCALS = local_mask(NUM_BP);

  logic [DW-1:0] d;

  always_comb begin
    d = q;
    if (task_sw) d = d & ~LOCALS;
    if (gd_clr)  d[CT_GD] = 1'b0;
    if (we)      d = wdata;
    d = d & CT_KEEP;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) q <= CT_RST;
    else        q <= d;
  end

  assign gd_en = q[CT_GD];

  AST_LOCAL_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (task_sw && !we) |=> ((q & LOCALS) == '0)); // R7

  AST_GLOBAL_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (task_sw && !we && !gd_clr) |=> ((q & ~LOCALS) == ($past(q) & ~LOCALS))); // R7

endmodule

// File: rtl/dbgreg_bank.sv
module dbgreg_bank
  import dbgreg_pkg::*;
#(
  parameter int unsigned NUM_BP = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc_valid,
  input  logic              acc_write,
  input  logic [2:0]        acc_idx,
  input  logic [1:0]        acc_cpl,
  input  logic [31:0]       acc_wdata,
  output logic [31:0]       acc_rdata,
  output logic [1:0]        acc_fault,
  input  logic [NUM_BP-1:0] bp_hit,
  input  logic              step_trap,
  input  logic              task_trap,
  input  logic              task_sw,
  input  logic              buslock_trap
);

  fault_e                     fault;
  logic [2:0]                 slot;
  logic                       rd_ok;
  logic [NUM_BP-1:0]          addr_we;
  logic                       stat_we;
  logic                       ctrl_we;
  logic                       db_event;
  logic                       gd_en;
  logic [NUM_BP-1:0][DW-1:0]  addr_q;
  logic [DW-1:0]              stat_q;
  logic [DW-1:0]              ctrl_q;

  dbgreg_access_gate #(.NUM_BP(NUM_BP)) u_gate (
    .acc_valid (acc_valid),
    .acc_write (acc_write),
    .acc_idx   (acc_idx),
    .acc_cpl   (acc_cpl),
    .gd_en     (gd_en),
    .fault     (fault),
    .slot      (slot),
    .rd_ok     (rd_ok),
    .addr_we   (addr_we),
    .stat_we   (stat_we),
    .ctrl_we   (ctrl_we),
    .db_event  (db_event)
  );

  dbgreg_addr_bank #(.NUM_BP(NUM_BP), .DW(DW)) u_addr (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (addr_we),
    .wdata (acc_wdata),
    .q     (addr_q)
  );

  dbgreg_status #(.NUM_BP(NUM_BP)) u_stat (
    .clk          (clk),
    .rst_n        (rst_n),
    .we           (stat_we),
    .wdata        (acc_wdata),
    .hit          (bp_hit),
    .step_trap    (step_trap),
    .task_trap    (task_trap),
    .buslock_trap (buslock_trap),
    .bd_set       (db_event),
    .q            (stat_q)
  );

  dbgreg_control #(.NUM_BP(NUM_BP)) u_ctrl (
    .clk     (clk),
    .rst_n   (rst_n),
    .we      (ctrl_we),
    .wdata   (acc_wdata),
    .task_sw (task_sw),
    .gd_clr  (db_event),
    .q       (ctrl_q),
    .gd_en   (gd_en)
  );

  always_comb begin
    acc_rdata = '0;
    if (rd_ok) begin
      if (slot == SLOT_STAT)      acc_rdata = stat_view(stat_q);
      else if (slot == SLOT_CTRL) acc_rdata = ctrl_view(ctrl_q);
      else begin
        for (int unsigned i = 0; i < NUM_BP; i++)
          if (slot == 3'(i)) acc_rdata = addr_q[i];
      end
    end
  end

  assign acc_fault = fault;

  AST_GP_ONLY_UNPRIV: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_fault == FLT_GP) |-> (acc_valid && acc_cpl != 2'd0)); // R4

  AST_FAULT_ZERO_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_fault != FLT_NONE) |-> (acc_rdata == '0)); // R4

  AST_GP_NO_STATE: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_fault == FLT_GP && !task_sw) |=> ($stable(ctrl_q) && $stable(addr_q))); // R4

  AST_BD_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stat_q[ST_BD]) |-> ($past(acc_fault == FLT_DB) || $past(stat_we))); // R5

  AST_DB_DROPS_GD: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_fault == FLT_DB) |=> (!gd_en && stat_q[ST_BD])); // R5

endmodule

// File: tb/tb_dbgreg_bank.sv
`timescale 1ns/1ps
module tb_dbgreg_bank;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        acc_valid, acc_write;
  logic [2:0]  acc_idx;
  logic [1:0]  acc_cpl;
  logic [31:0] acc_wdata;
  logic [31:0] acc_rdata;
  logic [1:0]  acc_fault;
  logic [3:0]  bp_hit;
  logic        step_trap, task_trap, task_sw, buslock_trap;

  int n_run  = 0;
  int n_fail = 0;
  bit done   = 0;

  localparam logic [1:0] F_NONE = 2'b00, F_GP = 2'b01, F_DB = 2'b10;

  always #2.5 clk = ~clk;

  dbgreg_bank dut (
    .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_write(acc_write),
    .acc_idx(acc_idx), .acc_cpl(acc_cpl), .acc_wdata(acc_wdata),
    .acc_rdata(acc_rdata), .acc_fault(acc_fault), .bp_hit(bp_hit),
    .step_trap(step_trap), .task_trap(task_trap), .task_sw(task_sw),
    .buslock_trap(buslock_trap)
  );

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %08h expected %08h", req, got, exp);
    end
  endtask

  task automatic idle();
    acc_valid = 0; acc_write = 0; acc_idx = 0; acc_cpl = 0; acc_wdata = 0;
    bp_hit = 0; step_trap = 0; task_trap = 0; task_sw = 0; buslock_trap = 0;
  endtask

  // one cycle: inputs set at negedge, outputs captured 1 ns later, idle at next negedge
  task automatic acc(input logic wr, input logic [2:0] idx, input logic [1:0] cpl,
                     input logic [31:0] wd, output logic [31:0] rd, output logic [1:0] flt);
    @(negedge clk);
    acc_valid = 1; acc_write = wr; acc_idx = idx; acc_cpl = cpl; acc_wdata = wd;
    #1; rd = acc_rdata; flt = acc_fault;
    @(negedge clk); idle();
  endtask

  task automatic rd_chk(input string req, input logic [2:0] idx, input logic [31:0] exp);
    logic [31:0] r; logic [1:0] f;
    acc(1'b0, idx, 2'd0, 32'h0, r, f);
    check(req, {30'h0, f}, {30'h0, F_NONE});
    check(req, r, exp);
  endtask

  task automatic wr(input logic [2:0] idx, input logic [31:0] wd);
    logic [31:0] r; logic [1:0] f;
    acc(1'b1, idx, 2'd0, wd, r, f);
  endtask

  task automatic do_reset();
    idle(); rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
  endtask

  task automatic t_reset();
    do_reset();
    for (int i = 0; i < 4; i++) rd_chk("R1 addr reset", 3'(i), 32'h0);
    rd_chk("R1 status reset", 3'd6, 32'hFFFF0FF0);
    rd_chk("R1 control reset", 3'd7, 32'h00000400);
  endtask

  task automatic t_addr();
    do_reset();
    for (int i = 0; i < 4; i++) wr(3'(i), 32'hA5000000 ^ (32'h01010101 * (i + 1)));
    for (int i = 0; i < 4; i++) rd_chk("R2 addr rw", 3'(i), 32'hA5000000 ^ (32'h01010101 * (i + 1)));
    wr(3'd2, 32'hFFFFFFFF);
    rd_chk("R2 addr all ones", 3'd2, 32'hFFFFFFFF);
  endtask

  task automatic t_alias();
    do_reset();
    wr(3'd5, 32'h000000C3);
    rd_chk("R3 ctrl via 7", 3'd7, 32'h000004C3);
    rd_chk("R3 ctrl via 5", 3'd5, 32'h000004C3);
    wr(3'd4, 32'h00000000);
    rd_chk("R3 status via 6", 3'd6, 32'hFFFF07F0);
    rd_chk("R3 status via 4", 3'd4, 32'hFFFF07F0);
  endtask

  task automatic t_fixed();
    do_reset();
    wr(3'd7, 32'hFFFFDFFF);
    rd_chk("R8 ctrl fixed bits", 3'd7, 32'hFFFF07FF);
    wr(3'd7, 32'h0);
    rd_chk("R8 ctrl bit10", 3'd7, 32'h00000400);
    wr(3'd6, 32'hFFFFFFFF);
    rd_chk("R9 status fixed ones", 3'd6, 32'hFFFFEFFF);
    wr(3'd6, 32'h0);
    rd_chk("R9 status fixed zero", 3'd6, 32'hFFFF07F0);
  endtask

  task automatic t_priv();
    logic [31:0] r; logic [1:0] f;
    do_reset();
    wr(3'd0, 32'h12345678);
    acc(1'b1, 3'd0, 2'd3, 32'hDEADBEEF, r, f);
    check("R4 gp code on write", {30'h0, f}, {30'h0, F_GP});
    acc(1'b1, 3'd7, 2'd1, 32'h000000FF, r, f);
    check("R4 gp code ctrl write", {30'h0, f}, {30'h0, F_GP});
    acc(1'b0, 3'd0, 2'd2, 32'h0, r, f);
    check("R4 gp code on read", {30'h0, f}, {30'h0, F_GP});
    check("R4 gp read data", r, 32'h0);
    rd_chk("R4 addr unchanged", 3'd0, 32'h12345678);
    rd_chk("R4 ctrl unchanged", 3'd7, 32'h00000400);
  endtask

  task automatic t_gd();
    logic [31:0] r; logic [1:0] f;
    do_reset();
    wr(3'd7, 32'h00002000);
    acc(1'b1, 3'd1, 2'd3, 32'h11111111, r, f);
    check("R6 gp before gd", {30'h0, f}, {30'h0, F_GP});
    acc(1'b0, 3'd6, 2'd1, 32'h0, r, f);
    check("R6 gp before gd read", {30'h0, f}, {30'h0, F_GP});
    acc(1'b1, 3'd1, 2'd0, 32'h22222222, r, f);
    check("R5 db code", {30'h0, f}, {30'h0, F_DB});
    check("R5 db read data", r, 32'h0);
    rd_chk("R5 bd set", 3'd6, 32'hFFFF2FF0);
    rd_chk("R5 gd cleared", 3'd7, 32'h00000400);
    rd_chk("R5 write blocked", 3'd1, 32'h0);
  endtask

  task automatic t_task_sw();
    do_reset();
    wr(3'd7, 32'h003300FF);
    @(negedge clk); task_sw = 1; @(negedge clk); idle();
    rd_chk("R7 locals cleared", 3'd7, 32'h003304AA);
    wr(3'd7, 32'h00000055);
    @(negedge clk); task_sw = 1; @(negedge clk); idle();
    rd_chk("R7 globals kept", 3'd7, 32'h00000400);
  endtask

  task automatic t_status_hw();
    do_reset();
    @(negedge clk); bp_hit = 4'b0101; step_trap = 1; task_trap = 1; @(negedge clk); idle();
    rd_chk("R13 merged strobes", 3'd6, 32'hFFFFCFF5);
    @(negedge clk); bp_hit = 4'b1010; @(negedge clk); idle();
    rd_chk("R10 hits sticky", 3'd6, 32'hFFFFCFFF);
    wr(3'd6, 32'h00000800);
    rd_chk("R10 sw clear", 3'd6, 32'hFFFF0FF0);
    @(negedge clk); step_trap = 1; @(negedge clk); idle();
    rd_chk("R11 step alone", 3'd6, 32'hFFFF4FF0);
  endtask

  task automatic t_buslock();
    do_reset();
    @(negedge clk); buslock_trap = 1; bp_hit = 4'b0001; @(negedge clk); idle();
    rd_chk("R12 bld cleared", 3'd6, 32'hFFFF07F1);
    @(negedge clk); step_trap = 1; task_trap = 1; @(negedge clk); idle();
    rd_chk("R12 bld stays low", 3'd6, 32'hFFFFC7F1);
    wr(3'd6, 32'h00000800);
    rd_chk("R12 sw sets bld", 3'd6, 32'hFFFF0FF0);
  endtask

  task automatic t_collide();
    do_reset();
    @(negedge clk);
    acc_valid = 1; acc_write = 1; acc_idx = 3'd6; acc_wdata = 32'h00000800;
    bp_hit = 4'b1111; step_trap = 1; buslock_trap = 1;
    @(negedge clk); idle();
    rd_chk("R13 status write wins", 3'd6, 32'hFFFF0FF0);
    @(negedge clk);
    acc_valid = 1; acc_write = 1; acc_idx = 3'd7; acc_wdata = 32'h00000055; task_sw = 1;
    @(negedge clk); idle();
    rd_chk("R13 ctrl write wins", 3'd7, 32'h00000455);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    idle(); rst_n = 0;
    t_reset();
    t_addr();
    t_alias();
    t_fixed();
    t_priv();
    t_gd();
    t_task_sw();
    t_status_hw();
    t_buslock();
    t_collide();
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule